// File: doc/BRIEF.md
# Serial Cyclic Code Multiplier Encoder

This block encodes a data word into a non-systematic cyclic code word by multiplying the data polynomial by a fixed generator polynomial over GF(2). It works one bit per clock. Data bits enter with a valid strobe. Each accepted bit yields one code bit on the following cycle. The product is formed by a chain of delay registers: each register is a multiplication by x, and the taps are combined with exclusive-OR. The code word is a whole product. The data bits therefore do not appear as a contiguous field of it, and a receiver must divide by the generator to recover them.

A word starts with a one-cycle start pulse, which clears every delay register. The source then supplies k data bits, highest-order coefficient first. After the last of them, the block feeds r = n-k zero bits into the chain by itself, so the high-order product terms drain out. Exactly n code bits leave per word, highest-order coefficient first, and a done pulse marks the last one. A start pulse issued in the middle of a word abandons that word and begins a fresh one.

The generator is set by two parameters: its degree and its coefficient vector. Bit i of the vector is the coefficient of x^i.

Top module: `cyclic_mul_encoder`

## Requirements
- R1: For every k-bit data word D, the n code bits that are emitted, read highest-order first, equal the carry-less product D(x)*G(x), where G(x) is the coefficient vector GEN_POLY (bit i is the coefficient of x^i).
- R2: With GEN_DEGREE=3 and GEN_POLY=4'b1101 (x^3+x^2+1), the data word 1101 encodes to the code word 1010001.
- R3: A data bit is accepted in a cycle in which dataValid is high, the encoder is loading, and start is low. codeValid is then high in the next cycle, carrying that bit's code bit. Bits accepted on consecutive cycles give code bits on consecutive cycles.
- R4: In the r cycles after the k-th data bit is accepted, the block emits the remaining r code bits with codeValid high, without input. dataValid and dataIn have no effect during these cycles.
- R5: done is high for exactly one cycle, in the same cycle as the n-th code bit of a word. It is low in the cycle that follows.
- R6: After reset, codeValid, codeOut and done are 0. Until a start pulse arrives, dataValid is ignored and no code bit is emitted.
- R7: A start pulse clears all delay registers and the bit count, and codeValid is low in the next cycle. A start pulse that arrives while a word is being loaded or flushed abandons that word. The next word encodes exactly as it would from reset.
- R8: A data bit presented in the same cycle as start is discarded.
- R9: A cycle in which dataValid is low during loading emits no code bit and leaves the partial product unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that clears the encoder and begins a word |
| dataValid | input | 1 | Marks dataIn as a data bit |
| dataIn | input | 1 | Serial data bit, highest-order coefficient first |
| codeValid | output | 1 | Marks codeOut as a code bit |
| codeOut | output | 1 | Serial code bit, highest-order coefficient first |
| done | output | 1 | High together with the last code bit of a word |

## Verification
Every code bit is due one cycle after the edge that accepted its data bit. The r flush bits follow on the r edges after the last data bit, and done coincides with the n-th bit. In the cycle after that, both codeValid and done are low again. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each sample lands exactly one register stage after its stimulus. Gap cycles, stray inputs during flush and cycles after a start pulse are each sampled at the falling edge that follows them, where codeValid must be low or the word must still come out intact.

// File: rtl/cyclic_mul_pkg.sv
package cyclic_mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_FLUSH = 2'd2
  } encState_t;

  typedef struct packed {
    logic clear;    // wipe delay chain and output registers
    logic shift;    // advance the chain by one bit
    logic feedBit;  // bit entering the chain
    logic last;     // this shift produces the final code bit
  } encCtl_t;

endpackage

// File: rtl/cyclic_mul_ctrl.sv
module cyclic_mul_ctrl
  import cyclic_mul_pkg::*;
#(
  parameter int DATA_BITS  = 4,
  parameter int GEN_DEGREE = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    dataValid,
  input  logic    dataIn,
  output encCtl_t ctl
);

  localparam int MAX_COUNT = (DATA_BITS > GEN_DEGREE) ? DATA_BITS : GEN_DEGREE;
  localparam int CNT_W     = (MAX_COUNT > 1) ? $clog2(MAX_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_FLUSH = CNT_W'(GEN_DEGREE - 1);

  encState_t        state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (start) begin
      state  <= ST_LOAD;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (dataValid) begin
            if (bitCnt == LAST_DATA) begin
              state  <= ST_FLUSH;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          if (bitCnt == LAST_FLUSH) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: begin
          state  <= ST_IDLE;
          bitCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    ctl.clear   = start;
    ctl.shift   = !start && (((state == ST_LOAD) && dataValid) || (state == ST_FLUSH));
    ctl.feedBit = (state == ST_LOAD) ? dataIn : 1'b0;
    ctl.last    = (state == ST_FLUSH) && (bitCnt == LAST_FLUSH);
  end

  // R4: the k-th accepted data bit moves the encoder into the flush phase
  p_flush_follows_load_r4 : assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && dataValid && !start && bitCnt == LAST_DATA) |=> (state == ST_FLUSH));

  // R7: any start pulse lands in the loading phase with an empty count
  p_start_restarts_r7 : assert property (@(posedge clk) disable iff (rst)
    start |=> (state == ST_LOAD && bitCnt == '0));

  // R6: with no start, the idle state is left alone whatever dataValid does
  p_idle_holds_r6 : assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));

endmodule

// File: rtl/cyclic_mul_datapath.sv
module cyclic_mul_datapath
  import cyclic_mul_pkg::*;
#(
  parameter int                  GEN_DEGREE = 3,
  parameter logic [GEN_DEGREE:0] GEN_POLY   = 4'b1101
) (
  input  logic    clk,
  input  logic    rst,
  input  encCtl_t ctl,
  output logic    codeOut,
  output logic    codeValid,
  output logic    done
);

  localparam int R = GEN_DEGREE;

  logic [R-1:0] hist;     // hist[i] = input bit from i+1 shifts ago
  logic [R:0]   tapTerm;
  logic         product;

  // Output bit: sum over j of g[R-j] * input(t-j)
  assign tapTerm[0] = GEN_POLY[R] & ctl.feedBit;
  for (genvar i = 1; i <= R; i++) begin : g_tap
    assign tapTerm[i] = GEN_POLY[R-i] & hist[i-1];
  end
  assign product = ^tapTerm;

  if (R == 1) begin : g_chain_one
    always_ff @(posedge clk) begin
      if (rst || ctl.clear) hist <= '0;
      else if (ctl.shift)   hist <= ctl.feedBit;
    end
  end else begin : g_chain_many
    always_ff @(posedge clk) begin
      if (rst || ctl.clear) hist <= '0;
      else if (ctl.shift)   hist <= {hist[R-2:0], ctl.feedBit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      codeOut   <= 1'b0;
      codeValid <= 1'b0;
      done      <= 1'b0;
    end else begin
      codeValid <= ctl.shift;
      done      <= ctl.shift && ctl.last;
      if (ctl.shift) codeOut <= product;
    end
  end

  // R7: a clear leaves an empty chain and no valid output
  p_clear_empties_r7 : assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> (hist == '0 && !codeValid && !done));

  // R9: without a shift the partial product is held
  p_hold_without_shift_r9 : assert property (@(posedge clk) disable iff (rst)
    (!ctl.shift && !ctl.clear) |=> $stable(hist));

  // R5: done only comes with a valid code bit
  p_done_with_valid_r5 : assert property (@(posedge clk) disable iff (rst)
    done |-> codeValid);

  // R5: done lasts a single cycle
  p_done_single_r5 : assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/cyclic_mul_encoder.sv
module cyclic_mul_encoder
  import cyclic_mul_pkg::*;
#(
  parameter int                  DATA_BITS  = 4,
  parameter int                  GEN_DEGREE = 3,
  parameter logic [GEN_DEGREE:0] GEN_POLY   = 4'b1101
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic dataValid,
  input  logic dataIn,
  output logic codeValid,
  output logic codeOut,
  output logic done
);

  encCtl_t ctl;

  cyclic_mul_ctrl #(
    .DATA_BITS (DATA_BITS),
    .GEN_DEGREE(GEN_DEGREE)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dataValid(dataValid),
    .dataIn   (dataIn),
    .ctl      (ctl)
  );

  cyclic_mul_datapath #(
    .GEN_DEGREE(GEN_DEGREE),
    .GEN_POLY  (GEN_POLY)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .codeOut  (codeOut),
    .codeValid(codeValid),
    .done     (done)
  );

  // R6/R3: a code bit appears only in the cycle after a shift strobe
  p_valid_needs_shift_r3 : assert property (@(posedge clk) disable iff (rst)
    !ctl.shift |=> !codeValid);

endmodule

// File: tb/cyclic_mul_encoder_tb.sv
module cyclic_mul_encoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int K = 4;
  localparam int R = 3;
  localparam int N = K + R;
  localparam logic [R:0] GEN = 4'b1101;

  // each entry: {data[3:0], gapBefore[3:0], junkDuringFlush}
  localparam logic [15:0][8:0] VECTORS = {
    {4'h0, 4'b0000, 1'b0}, {4'h1, 4'b0001, 1'b1}, {4'h2, 4'b1000, 1'b0}, {4'h3, 4'b0000, 1'b1},
    {4'h4, 4'b0101, 1'b0}, {4'h5, 4'b0000, 1'b0}, {4'h6, 4'b0010, 1'b1}, {4'h7, 4'b1111, 1'b0},
    {4'h8, 4'b0000, 1'b1}, {4'h9, 4'b0100, 1'b0}, {4'hA, 4'b0000, 1'b1}, {4'hB, 4'b1010, 1'b1},
    {4'hC, 4'b0000, 1'b0}, {4'hD, 4'b0011, 1'b0}, {4'hE, 4'b0000, 1'b1}, {4'hF, 4'b1001, 1'b0}
  };

  logic clk = 1'b0;
  logic rst, start, dataValid, dataIn;
  logic codeValid, codeOut, done;
  int   checks = 0;
  int   failures = 0;
  int   cycles = 0;

  cyclic_mul_encoder #(.DATA_BITS(K), .GEN_DEGREE(R), .GEN_POLY(GEN)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dataValid(dataValid), .dataIn(dataIn),
    .codeValid(codeValid), .codeOut(codeOut), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [N-1:0] clmul(input logic [K-1:0] d);
    logic [N-1:0] acc = '0;
    for (int i = 0; i < K; i++) if (d[i]) acc ^= (N'(GEN) << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Encode one word starting with a start pulse; returns the collected code word.
  task automatic runWord(input logic [K-1:0] d, input logic [K-1:0] gaps, input logic junk,
                         input logic bitAtStart, output logic [N-1:0] code);
    code = '0;
    start = 1'b1; dataValid = bitAtStart; dataIn = 1'b1;
    @(negedge clk);
    start = 1'b0; dataValid = 1'b0;
    check("R7 start clears codeValid", 32'(codeValid), 32'd0);
    for (int i = K-1; i >= 0; i--) begin
      if (gaps[i]) begin
        dataValid = 1'b0;
        @(negedge clk);
        check("R9 gap emits nothing", 32'(codeValid), 32'd0);
      end
      dataValid = 1'b1; dataIn = d[i];
      @(negedge clk);
      check("R3 code bit one cycle after data", 32'(codeValid), 32'd1);
      check("R5 no early done", 32'(done), 32'd0);
      code = {code[N-2:0], codeOut};
    end
    for (int j = 0; j < R; j++) begin
      dataValid = junk; dataIn = junk;
      @(negedge clk);
      check("R4 flush bit valid", 32'(codeValid), 32'd1);
      check("R5 done on last bit only", 32'(done), (j == R-1) ? 32'd1 : 32'd0);
      code = {code[N-2:0], codeOut};
    end
    dataValid = 1'b0; dataIn = 1'b0;
    @(negedge clk);
    check("R5 done drops after one cycle", 32'(done), 32'd0);
    check("R4 no extra code bit", 32'(codeValid), 32'd0);
  endtask

  task automatic partialWord(input logic [K-1:0] bits, input int count);
    start = 1'b1; dataValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < count; i++) begin
      dataValid = 1'b1; dataIn = bits[K-1-(i % K)];
      @(negedge clk);
    end
    dataValid = 1'b0;
  endtask

  initial begin
    logic [N-1:0] code;
    rst = 1'b1; start = 1'b0; dataValid = 1'b0; dataIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 reset codeValid", 32'(codeValid), 32'd0);
    check("R6 reset codeOut", 32'(codeOut), 32'd0);
    check("R6 reset done", 32'(done), 32'd0);
    rst = 1'b0;

    // R6: data without start is ignored
    for (int i = 0; i < 4; i++) begin
      dataValid = 1'b1; dataIn = i[0];
      @(negedge clk);
      check("R6 idle ignores dataValid", 32'(codeValid), 32'd0);
    end
    dataValid = 1'b0;

    // R1: all data words, varied gaps and flush junk
    for (int v = 0; v < 16; v++) begin
      runWord(VECTORS[v][8:5], VECTORS[v][4:1], VECTORS[v][0], 1'b0, code);
      check("R1 code equals carry-less product", 32'(code), 32'(clmul(VECTORS[v][8:5])));
    end

    // R2: worked example
    runWord(4'b1101, 4'b0000, 1'b0, 1'b0, code);
    check("R2 1101 encodes to 1010001", 32'(code), 32'b1010001);

    // R8: bit in start cycle is dropped
    runWord(4'b1101, 4'b0000, 1'b0, 1'b1, code);
    check("R8 start-cycle bit discarded", 32'(code), 32'b1010001);

    // R7: abort during loading
    partialWord(4'b1111, 2);
    runWord(4'b1101, 4'b0000, 1'b0, 1'b0, code);
    check("R7 abort during load", 32'(code), 32'b1010001);

    // R7: abort during flush
    partialWord(4'b1011, K);
    @(negedge clk);
    runWord(4'b0110, 4'b0100, 1'b1, 1'b0, code);
    check("R7 abort during flush", 32'(code), 32'(clmul(4'b0110)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule